// File: doc/BRIEF.md
# Oversampled Serial Receiver with NRZ and Infrared Pulse Decoding

This block receives asynchronous serial frames of one start bit, a configurable number of data bits sent least-significant first, and one stop bit. It is advanced by a single-cycle enable, `os_tick`, that runs at sixteen times the bit rate. Each enabled clock edge is one oversample slot. Slots are numbered RT1 to RT16 within a bit period, and RT1 is the slot in which the start bit is first seen low.

The input can be plain NRZ or infrared-style pulse encoding. In pulse encoding, a zero is a short pulse inside the bit period and a one is a bit period with no pulse. `inv_pol` swaps the active line level in either format. A pulse is stretched to one full bit period before the data is sampled, so both formats reach the frame logic as the same logical level stream.

At the end of each frame the block presents the data word with a one-cycle valid strobe. It also reports a framing-error flag and a break flag, and both flags are held until the next frame completes. A receiver-active flag rises when a start bit is first seen and falls only after a full idle character has been observed.

Top module: `uart_irda_rx`

## Requirements
- R1: With `irda_en`=0 and `inv_pol`=0, a high line is logical 1 and a low line is logical 0. A frame is a 0 start bit, DATA_BITS data bits sent least-significant first, and a stop bit. When the stop bit is decided, `rx_data` takes the word and `rx_valid` is high for exactly one clock.
- R2: With `irda_en`=0 and `inv_pol`=1, a low line is logical 1 and a high line is logical 0, and frames otherwise decode as in R1.
- R3: With `irda_en`=1 and `inv_pol`=0, the line idles low. A high pulse of one or more slots within a bit period is a logical 0, and that 0 is held for 16 slots from the pulse's first slot. A bit period with no pulse is a logical 1.
- R4: With `irda_en`=1 and `inv_pol`=1, the line idles high, a low pulse is a logical 0, and a bit period with no pulse is a logical 1.
- R5: The start bit is confirmed by a majority of the samples at RT3, RT5 and RT7. If that majority is 1, the receiver returns to searching and no `rx_valid` is produced.
- R6: Each data bit and the stop bit are decided by a majority of the samples at RT8, RT9 and RT10. A single-slot inversion at RT9 does not change the decoded bit.
- R7: When the stop bit is decided as 0, `frame_err` is set for that frame. When it is decided as 1, `frame_err` is cleared. `frame_err` and `break_det` are held until the next frame completes.
- R8: A frame whose data bits and stop bit are all 0 sets both `break_det` and `frame_err` and delivers `rx_data`=0. After any framing error the receiver does not search for a new start bit until the line has returned to logical 1.
- R9: `rx_active` is set in the slot where a logical 0 is first seen during the start-bit search (RT1). It stays set after a start bit that fails the vote.
- R10: `rx_active` is cleared after (DATA_BITS+2)×16 consecutive slots of logical 1. It is not cleared after fewer than that.
- R11: While `rst_n` is low, `rx_valid`, `frame_err`, `break_det` and `rx_active` are 0 and `rx_data` is 0.
- R12: Nothing advances on clock edges where `os_tick` is 0, so frames decode correctly when `os_tick` is high only one clock in several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_in | input | 1 | Serial line |
| irda_en | input | 1 | 1 = pulse-encoded input, 0 = NRZ |
| inv_pol | input | 1 | 1 = inverted line polarity |
| rx_data | output | DATA_BITS | Last received word |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |
| frame_err | output | 1 | Stop bit of the last frame was 0 |
| break_det | output | 1 | Last frame was all zeros, including the stop bit |
| rx_active | output | 1 | Reception in progress since the last idle character |

## Verification
The assertions assume that `rx_in` holds one level for a whole oversample slot, and that `irda_en` and `inv_pol` change only while the line sits at its logical idle level. They also assume that `os_tick` never stays high long enough for two frames to end on adjacent clocks. The bench drives `rx_in` once per slot, right after the clock edge that carries `os_tick`. Before it switches format or polarity, it first moves the line to the idle level of the new setting, so the polarity change never creates a false start bit. Glitches are injected only at RT1–RT2 and RT9, where the voting rules fix the expected outcome.

// File: rtl/uart_irda_rx_pkg.sv
package uart_irda_rx_pkg;

  localparam int OSR  = 16;
  localparam int RT_W = $clog2(OSR);

  // start-bit vote slots RT3, RT5, RT7 (zero-based index)
  localparam int ST_VA = OSR / 8;
  localparam int ST_VB = OSR / 4;
  localparam int ST_VC = (3 * OSR) / 8;
  // bit vote slots RT8, RT9, RT10 (zero-based index)
  localparam int BT_VA = OSR / 2 - 1;
  localparam int BT_VB = OSR / 2;
  localparam int BT_VC = OSR / 2 + 1;

  typedef enum logic [2:0] {
    RX_SEARCH,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic int idle_slots(input int data_bits);
    return OSR * (data_bits + 2);
  endfunction

endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond
  import uart_irda_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_in,
  input  logic irda_en,
  input  logic inv_pol,
  output logic line_one
);

  logic            lraw;
  logic [1:0]      sync_q;
  logic            zero_now;
  logic            zero_prev;
  logic [RT_W-1:0] stretch_cnt;
  logic            pulse_rise;

  // polarity and format are folded in before the synchronizer so that a
  // config change and a matching line change travel together
  assign lraw = irda_en ? ~(rx_in ^ inv_pol) : (rx_in ^ inv_pol);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], lraw};
  end

  assign zero_now   = ~sync_q[1];
  assign pulse_rise = tick & irda_en & zero_now & ~zero_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_prev   <= 1'b0;
      stretch_cnt <= '0;
    end else if (tick) begin
      zero_prev <= zero_now;
      if (pulse_rise)              stretch_cnt <= RT_W'(OSR - 1);
      else if (stretch_cnt != '0)  stretch_cnt <= stretch_cnt - 1'b1;
    end
  end

  assign line_one = ~(zero_now | (irda_en & (stretch_cnt != '0)));

  // R3
  pulse_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_rise |=> !line_one);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_irda_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_one,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 break_det,
  output logic                 start_seen,
  output logic                 frame_done
);

  localparam int BC_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rx_state_e            state;
  logic [RT_W-1:0]      rt;
  logic [BC_W-1:0]      bitcnt;
  logic                 samp_a, samp_b;
  logic [DATA_BITS-1:0] shreg;
  logic                 bit_vote;

  assign bit_vote   = vote3(samp_a, samp_b, line_one);
  assign start_seen = tick & (state == RX_SEARCH) & ~line_one;
  assign frame_done = tick & (state == RX_STOP) & (rt == RT_W'(BT_VC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_SEARCH;
      rt        <= '0;
      bitcnt    <= '0;
      samp_a    <= 1'b1;
      samp_b    <= 1'b1;
      shreg     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      break_det <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_SEARCH: begin
            if (!line_one) begin
              state <= RX_START;
              rt    <= RT_W'(1);
            end
          end
          RX_START: begin
            rt <= rt + 1'b1;
            if (rt == RT_W'(ST_VA)) samp_a <= line_one;
            if (rt == RT_W'(ST_VB)) samp_b <= line_one;
            if (rt == RT_W'(ST_VC) && bit_vote) state <= RX_SEARCH;
            else if (rt == RT_W'(OSR - 1)) begin
              state  <= RX_DATA;
              bitcnt <= '0;
            end
          end
          RX_DATA: begin
            rt <= rt + 1'b1;
            if (rt == RT_W'(BT_VA)) samp_a <= line_one;
            if (rt == RT_W'(BT_VB)) samp_b <= line_one;
            if (rt == RT_W'(BT_VC)) shreg <= {bit_vote, shreg[DATA_BITS-1:1]};
            if (rt == RT_W'(OSR - 1)) begin
              if (bitcnt == BC_W'(DATA_BITS - 1)) state <= RX_STOP;
              else                                bitcnt <= bitcnt + 1'b1;
            end
          end
          RX_STOP: begin
            rt <= rt + 1'b1;
            if (rt == RT_W'(BT_VA)) samp_a <= line_one;
            if (rt == RT_W'(BT_VB)) samp_b <= line_one;
            if (rt == RT_W'(BT_VC)) begin
              rx_valid  <= 1'b1;
              rx_data   <= shreg;
              frame_err <= ~bit_vote;
              break_det <= ~bit_vote & (shreg == '0);
              state     <= bit_vote ? RX_SEARCH : RX_WAIT_HIGH;
            end
          end
          RX_WAIT_HIGH: begin
            if (line_one) state <= RX_SEARCH;
          end
          default: state <= RX_SEARCH;
        endcase
      end
    end
  end

  // R1
  valid_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  break_has_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> frame_err);

  // R8
  break_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> (rx_data == '0));

  // R7
  valid_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_valid);

endmodule

// File: rtl/rx_idle_mon.sv
module rx_idle_mon #(
  parameter int IDLE_SLOTS = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_one,
  input  logic start_seen,
  output logic rx_active
);

  localparam int CNT_W = $clog2(IDLE_SLOTS + 1);

  logic [CNT_W-1:0] ones_cnt;
  logic             idle_hit;

  assign idle_hit = tick & line_one & (ones_cnt == CNT_W'(IDLE_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_cnt  <= '0;
      rx_active <= 1'b0;
    end else begin
      if (tick) begin
        if (!line_one)                          ones_cnt <= '0;
        else if (ones_cnt != CNT_W'(IDLE_SLOTS)) ones_cnt <= ones_cnt + 1'b1;
      end
      if (start_seen)    rx_active <= 1'b1;
      else if (idle_hit) rx_active <= 1'b0;
    end
  end

  // R10
  drop_after_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> $past(line_one));

  // R9
  rise_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(!line_one));

endmodule

// File: rtl/uart_irda_rx.sv
module uart_irda_rx
  import uart_irda_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rx_in,
  input  logic                 irda_en,
  input  logic                 inv_pol,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 break_det,
  output logic                 rx_active
);

  localparam int IDLE_SLOTS = idle_slots(DATA_BITS);

  logic line_one;
  logic start_seen;
  logic frame_done;

  rx_line_cond u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .rx_in    (rx_in),
    .irda_en  (irda_en),
    .inv_pol  (inv_pol),
    .line_one (line_one)
  );

  rx_frame_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (os_tick),
    .line_one   (line_one),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .frame_err  (frame_err),
    .break_det  (break_det),
    .start_seen (start_seen),
    .frame_done (frame_done)
  );

  rx_idle_mon #(.IDLE_SLOTS(IDLE_SLOTS)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (os_tick),
    .line_one   (line_one),
    .start_seen (start_seen),
    .rx_active  (rx_active)
  );

  // R9
  valid_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);

endmodule

// File: tb/uart_irda_rx_bench.sv
module uart_irda_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rx_in;
  logic       irda_en;
  logic       inv_pol;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       frame_err;
  logic       break_det;
  logic       rx_active;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int cycles = 0;
  int div    = 1;
  int tcnt   = 0;

  always #4 clk = ~clk;

  uart_irda_rx #(.DATA_BITS(8)) u_uart_irda_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .rx_in     (rx_in),
    .irda_en   (irda_en),
    .inv_pol   (inv_pol),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .break_det (break_det),
    .rx_active (rx_active)
  );

  always @(negedge clk) tcnt <= (tcnt + 1 >= div) ? 0 : tcnt + 1;
  assign os_tick = (tcnt == 0);

  always @(negedge clk) if (rx_valid) vcount++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic       ir;
    logic       iv;
    logic [7:0] d;
    logic       stp;
    logic       fe;
    logic       brk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0},  // R1
    '{1'b0, 1'b0, 8'hA3, 1'b1, 1'b0, 1'b0},  // R1
    '{1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0},  // R2
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},  // R2
    '{1'b1, 1'b0, 8'hC5, 1'b1, 1'b0, 1'b0},  // R3
    '{1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0},  // R3
    '{1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0},  // R4
    '{1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},  // R4
    '{1'b0, 1'b0, 8'h7E, 1'b0, 1'b1, 1'b0},  // R7
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},  // R8
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}   // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one oversample slot at level v; entered and left at a falling edge
  task automatic hold(input logic v);
    logic seen;
    rx_in = v;
    seen = 1'b0;
    while (!seen) begin
      @(posedge clk);
      seen = os_tick;
    end
    @(negedge clk);
  endtask

  function automatic logic idle_level(input logic ir, input logic iv);
    return ir ? iv : ~iv;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) hold(idle_level(irda_en, inv_pol));
  endtask

  task automatic set_cfg(input logic ir, input logic iv);
    irda_en = ir;
    inv_pol = iv;
    rx_in   = idle_level(ir, iv);
  endtask

  // pulse encoding: a 0 is a pulse in slots 6..8 of its bit period
  task automatic send_frame(input logic [7:0] d, input logic stp, input logic [9:0] flip);
    logic [9:0] fr;
    fr = {stp, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      for (int k = 0; k < 16; k++) begin
        logic lv;
        logic rv;
        lv = fr[b];
        if (flip[b] && k == 8) lv = ~lv;
        if (irda_en) rv = (!lv && k >= 6 && k <= 8) ? ~inv_pol : inv_pol;
        else         rv = lv ^ inv_pol;
        hold(rv);
      end
    end
  endtask

  initial begin
    int v0;
    rst_n = 1'b0;
    set_cfg(1'b0, 1'b0);
    repeat (5) @(negedge clk);
    // R11
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 frame_err", frame_err, 0);
    chk("R11 break_det", break_det, 0);
    chk("R11 rx_active", rx_active, 0);
    chk("R11 rx_data", rx_data, 0);
    rst_n = 1'b1;
    idle(10);

    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].ir, VECS[i].iv);
      idle(20);
      v0 = vcount;
      send_frame(VECS[i].d, VECS[i].stp, 10'h000);
      idle(6);
      chk($sformatf("R1 vec%0d strobe count", i), vcount - v0, 1);
      chk($sformatf("R2-4 vec%0d data", i), rx_data, VECS[i].d);
      chk($sformatf("R7 vec%0d frame_err", i), frame_err, VECS[i].fe);
      chk($sformatf("R8 vec%0d break_det", i), break_det, VECS[i].brk);
    end

    // R8: after a break the line stays low; no new start until it goes high
    set_cfg(1'b0, 1'b0);
    idle(20);
    v0 = vcount;
    send_frame(8'h00, 1'b0, 10'h000);
    for (int i = 0; i < 40; i++) hold(1'b0);
    idle(30);
    chk("R8 single strobe over long low", vcount - v0, 1);
    chk("R8 break held", break_det, 1);

    // R7: a good frame clears held flags
    v0 = vcount;
    send_frame(8'h5A, 1'b1, 10'h000);
    idle(6);
    chk("R7 fe cleared", frame_err, 0);
    chk("R7 data", rx_data, 8'h5A);

    // R6: one-slot inversions at RT9 of every data bit and the stop bit
    idle(20);
    v0 = vcount;
    send_frame(8'h0F, 1'b1, 10'b11_1111_1110);
    idle(6);
    chk("R6 glitch strobe", vcount - v0, 1);
    chk("R6 glitch data", rx_data, 8'h0F);
    chk("R6 glitch fe", frame_err, 0);

    // R10: full idle clears the active flag
    idle(200);
    chk("R10 idle cleared", rx_active, 0);

    // R5 / R9: two-slot low fails the start vote but sets active
    v0 = vcount;
    hold(1'b0);
    hold(1'b0);
    idle(4);
    chk("R9 active set", rx_active, 1);
    idle(144);
    chk("R5 no strobe after false start", vcount - v0, 0);
    chk("R10 active before full idle", rx_active, 1);
    idle(24);
    chk("R10 active after full idle", rx_active, 0);

    // R12: tick only every third clock
    div = 3;
    idle(20);
    v0 = vcount;
    send_frame(8'h96, 1'b1, 10'h000);
    idle(6);
    chk("R12 slow tick strobe", vcount - v0, 1);
    chk("R12 slow tick data", rx_data, 8'h96);
    chk("R12 slow tick fe", frame_err, 0);
    div = 1;
    idle(10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule